// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block keeps the interrupt presentation state of a single processor. It holds a 32-bit pending word whose top byte is the processor's current priority threshold and whose low 24 bits name the source currently being presented (zero means none). Next to it sit a pending-priority byte and a request-priority byte for inter-processor interrupts. Priorities use an inverted scale: the smaller value is the more favoured one, and 0xFF means "nothing".

A source unit offers interrupts (source number plus priority) over a valid/ready channel. The processor side issues commands over a second valid/ready channel: accept, end-of-interrupt, threshold write, IPI-request write and poll. The block answers accept and poll with a one-cycle response. It drives a single interrupt line. Back to the source unit it sends three one-cycle pulses: reject (with a source number), end-of-interrupt (with a source number) and a bare resend request. The block takes one operation per clock. The command channel is never stalled. A command in the same cycle as an offer wins, and the offer is held off by dropping its ready. The response and indication outputs carry no ready, so the receiver must take them in the cycle they appear.

Top module: `ipc_presenter`

## Requirements
- R1: After reset the pending word is 0, the IPI request priority is 0xFF, the pending priority is 0xFF, the interrupt line is low and no pulse or response is active.
- R2: cmd_ready is always 1 and offer_ready equals the inverse of cmd_valid. An operation accepted at a rising edge shows its state change, pulses and response in the cycle right after that edge. irq_o is high exactly while a nonzero source is latched.
- R3: An offer whose priority is greater than or equal to the threshold (bits 31:24) is rejected: a reject pulse carries the offered source and the state is unchanged.
- R4: An offer is also rejected when a source is pending whose pending priority is less than or equal to the offered priority.
- R5: Any other offer displaces the pending source, if there is one, with a reject pulse carrying the displaced number. It then latches the new source (bits 23:0) and priority and raises irq_o.
- R6: Accept (opcode 0) returns the whole pending word on rsp_word and lowers irq_o. It loads the threshold with the old pending priority, clears the source field and sets the pending priority to 0xFF.
- R7: EOI (opcode 1) copies cmd_data[31:24] into the threshold and pulses eoi_valid with eoi_src = cmd_data[23:0]. If no source is pending it also performs a resend, as defined in R9.
- R8: A threshold write (opcode 2, value in cmd_data[7:0]) that is more favoured than the old threshold, while a source is pending whose priority is not below the new value, clears the source. It sets the pending priority to 0xFF, lowers irq_o and rejects that source. A more favoured write that does not meet this condition changes only the threshold.
- R9: A threshold write that is not more favoured, with nothing pending, performs a resend. A resend pulses resend_valid and, if the IPI request priority is below the threshold, runs the IPI check of R10.
- R10: Writing the IPI request priority (opcode 3, cmd_data[7:0]) to a value below the threshold runs the IPI check. The IPI is presented only when nothing is pending or the pending priority is greater than the request. Presenting it rejects any displaced source, latches source number 2 with the request value as priority and raises irq_o.
- R11: Poll (opcode 4) returns the pending word on rsp_word and the IPI request priority on rsp_mfrr, and changes no state and not the interrupt line.
- R12: Opcodes 5 to 7 have no effect on state, pulses or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Offered interrupt present |
| offer_ready | output | 1 | Offer taken this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken (always 1) |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Response pulse for accept or poll |
| rsp_word | output | 32 | Returned pending word |
| rsp_mfrr | output | 8 | Returned IPI request priority (poll) |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source unit |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source unit |
| eoi_src | output | 24 | Source number ending service |
| resend_valid | output | 1 | Resend request pulse to the source unit |

## Verification
The hardest state to reach is a resend that presents an IPI inside the same threshold write. It needs a request priority already stored below a future threshold, no source pending, and a threshold write that relaxes the mask. The stimulus gets there in steps. It presents an IPI, then displaces it with a more favoured request. Next it clears that request with a strict threshold write. Finally it loosens the threshold, and one write must both pulse resend and raise the line with source 2.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT   = 3'd0,
    OP_EOI      = 3'd1,
    OP_SET_CPPR = 3'd2,
    OP_SET_MFRR = 3'd3,
    OP_POLL     = 3'd4
  } ipc_op_e;
endpackage

// File: rtl/ipc_offer_eval.sv
// Decides whether an offered source beats the threshold and the pending one.
module ipc_offer_eval #(
  parameter int PRIO_W = 8
) (
  input  logic              has_pend,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              take,
  output logic              displace
);
  logic blocked_thr, blocked_pend;
  always_comb begin
    blocked_thr  = (cand_prio >= cppr);
    blocked_pend = has_pend && (pend_prio <= cand_prio);
    take         = !blocked_thr && !blocked_pend;
    displace     = take && has_pend;
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
// IPI check: request must beat the threshold and the pending priority.
module ipc_ipi_eval #(
  parameter int PRIO_W = 8
) (
  input  logic              en,
  input  logic              has_pend,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] mfrr,
  output logic              fire,
  output logic              displace
);
  logic below_thr, pend_wins;
  always_comb begin
    below_thr = (mfrr < cppr);
    pend_wins = has_pend && (pend_prio <= mfrr);
    fire      = en && below_thr && !pend_wins;
    displace  = fire && has_pend;
  end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      offer_valid,
  output logic                      offer_ready,
  input  logic [SRC_W-1:0]          offer_src,
  input  logic [PRIO_W-1:0]         offer_prio,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [2:0]                cmd_op,
  input  logic [SRC_W+PRIO_W-1:0]   cmd_data,
  output logic                      rsp_valid,
  output logic [SRC_W+PRIO_W-1:0]   rsp_word,
  output logic [PRIO_W-1:0]         rsp_mfrr,
  output logic                      irq_o,
  output logic                      rej_valid,
  output logic [SRC_W-1:0]          rej_src,
  output logic                      eoi_valid,
  output logic [SRC_W-1:0]          eoi_src,
  output logic                      resend_valid
);
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

  // architectural state
  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic              irq_q;
  // next state
  logic [PRIO_W-1:0] cppr_n, pend_n, mfrr_n;
  logic [SRC_W-1:0]  xisr_n;
  logic              irq_n;
  // registered pulses
  logic              rsp_v_n, rej_v_n, eoi_v_n, rsnd_v_n;
  logic [WORD_W-1:0] rsp_w_n;
  logic [PRIO_W-1:0] rsp_m_n;
  logic [SRC_W-1:0]  rej_s_n, eoi_s_n;

  logic cmd_fire, offer_fire, has_pend;
  logic [PRIO_W-1:0] d_lo, d_hi;
  logic thr_tighter;

  assign cmd_ready   = 1'b1;
  assign offer_ready = ~cmd_valid;
  assign cmd_fire    = cmd_valid;
  assign offer_fire  = offer_valid && !cmd_valid;
  assign has_pend    = (xisr_q != '0);
  assign d_lo        = cmd_data[PRIO_W-1:0];
  assign d_hi        = cmd_data[WORD_W-1:SRC_W];
  assign thr_tighter = (d_lo < cppr_q);

  // operand selection for the IPI check (threshold/request after this op)
  logic              chk_en;
  logic [PRIO_W-1:0] chk_cppr, chk_mfrr;
  always_comb begin
    chk_en   = 1'b0;
    chk_cppr = cppr_q;
    chk_mfrr = mfrr_q;
    if (cmd_fire) begin
      case (cmd_op)
        OP_EOI: begin
          chk_cppr = d_hi;
          chk_en   = !has_pend;
        end
        OP_SET_CPPR: begin
          chk_cppr = d_lo;
          chk_en   = !thr_tighter && !has_pend;
        end
        OP_SET_MFRR: begin
          chk_mfrr = d_lo;
          chk_en   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic ipi_fire, ipi_disp, off_take, off_disp;

  ipc_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
    .en       (chk_en),
    .has_pend (has_pend),
    .pend_prio(pend_q),
    .cppr     (chk_cppr),
    .mfrr     (chk_mfrr),
    .fire     (ipi_fire),
    .displace (ipi_disp)
  );

  ipc_offer_eval #(.PRIO_W(PRIO_W)) u_offer (
    .has_pend (has_pend),
    .pend_prio(pend_q),
    .cppr     (cppr_q),
    .cand_prio(offer_prio),
    .take     (off_take),
    .displace (off_disp)
  );

  always_comb begin
    cppr_n   = cppr_q;
    pend_n   = pend_q;
    mfrr_n   = mfrr_q;
    xisr_n   = xisr_q;
    irq_n    = irq_q;
    rsp_v_n  = 1'b0;
    rsp_w_n  = {cppr_q, xisr_q};
    rsp_m_n  = mfrr_q;
    rej_v_n  = 1'b0;
    rej_s_n  = '0;
    eoi_v_n  = 1'b0;
    eoi_s_n  = '0;
    rsnd_v_n = 1'b0;
    if (cmd_fire) begin
      case (cmd_op)
        OP_ACCEPT: begin
          rsp_v_n = 1'b1;
          cppr_n  = pend_q;
          xisr_n  = '0;
          pend_n  = PRIO_NONE;
          irq_n   = 1'b0;
        end
        OP_EOI: begin
          cppr_n   = d_hi;
          eoi_v_n  = 1'b1;
          eoi_s_n  = cmd_data[SRC_W-1:0];
          rsnd_v_n = !has_pend;
        end
        OP_SET_CPPR: begin
          cppr_n = d_lo;
          if (thr_tighter) begin
            if (has_pend && (d_lo <= pend_q)) begin
              rej_v_n = 1'b1;
              rej_s_n = xisr_q;
              xisr_n  = '0;
              pend_n  = PRIO_NONE;
              irq_n   = 1'b0;
            end
          end else if (!has_pend) begin
            rsnd_v_n = 1'b1;
          end
        end
        OP_SET_MFRR: mfrr_n = d_lo;
        OP_POLL:     rsp_v_n = 1'b1;
        default: ;
      endcase
      if (ipi_fire) begin
        if (ipi_disp) begin
          rej_v_n = 1'b1;
          rej_s_n = xisr_q;
        end
        xisr_n = SRC_IPI;
        pend_n = chk_mfrr;
        irq_n  = 1'b1;
      end
    end else if (offer_fire) begin
      if (off_take) begin
        if (off_disp) begin
          rej_v_n = 1'b1;
          rej_s_n = xisr_q;
        end
        xisr_n = offer_src;
        pend_n = offer_prio;
        irq_n  = 1'b1;
      end else begin
        rej_v_n = 1'b1;
        rej_s_n = offer_src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q       <= '0;
      xisr_q       <= '0;
      pend_q       <= PRIO_NONE;
      mfrr_q       <= PRIO_NONE;
      irq_q        <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_word     <= '0;
      rsp_mfrr     <= '0;
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_valid <= 1'b0;
    end else begin
      cppr_q       <= cppr_n;
      xisr_q       <= xisr_n;
      pend_q       <= pend_n;
      mfrr_q       <= mfrr_n;
      irq_q        <= irq_n;
      rsp_valid    <= rsp_v_n;
      rsp_word     <= rsp_w_n;
      rsp_mfrr     <= rsp_m_n;
      rej_valid    <= rej_v_n;
      rej_src      <= rej_s_n;
      eoi_valid    <= eoi_v_n;
      eoi_src      <= eoi_s_n;
      resend_valid <= rsnd_v_n;
    end
  end

  assign irq_o = irq_q;

  // line follows the latched source
  assert_irq_follows_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (xisr_q != '0));
  // a presented source never carries the "none" priority
  assert_pend_prio_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (pend_q != PRIO_NONE));
  // offers held off while a command is present
  assert_cmd_beats_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !offer_ready);
  // poll leaves state alone
  assert_poll_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POLL) |=>
      ($stable(xisr_q) && $stable(cppr_q) && $stable(mfrr_q) && $stable(irq_q)));
  // rejects always name a real source
  assert_reject_names_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0));
  // accept always leaves nothing presented
  assert_accept_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACCEPT) |=> !irq_o);
  // undefined opcodes do nothing
  assert_undef_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > 3'd4) |=>
      (!rsp_valid && !rej_valid && !eoi_valid && !resend_valid && $stable(xisr_q)));
endmodule

// File: tb/ipc_presenter_test.sv
module ipc_presenter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_mfrr;
  logic        irq_o;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        resend_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_src(offer_src), .offer_prio(offer_prio),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_mfrr(rsp_mfrr),
    .irq_o(irq_o), .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // drive a command for one edge; outputs sampled 1 time unit after the edge
  task automatic do_cmd(logic [2:0] op, logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic do_offer(logic [23:0] src, logic [7:0] prio);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = src; offer_prio = prio;
    @(posedge clk); #1;
    offer_valid = 1'b0;
  endtask

  task automatic poll_expect(string req, logic [31:0] word, logic [7:0] mfrr);
    do_cmd(3'd4, 32'h0);
    check({req, " poll valid"}, 32'(rsp_valid), 32'd1);
    check({req, " poll word"}, rsp_word, word);
    check({req, " poll mfrr"}, 32'(rsp_mfrr), 32'(mfrr));
  endtask

  task automatic t_reset_R1;
    check("R1 irq low", 32'(irq_o), 0);
    check("R1 no pulses", 32'({rsp_valid, rej_valid, eoi_valid, resend_valid}), 0);
    check("R2 cmd_ready", 32'(cmd_ready), 1);
    poll_expect("R1", 32'h0, 8'hFF);
  endtask

  task automatic t_offer_blocked_R3;
    do_offer(24'h5, 8'h3);  // threshold 0 masks everything
    check("R3 reject", 32'(rej_valid), 1);
    check("R3 reject src", 32'(rej_src), 32'h5);
    check("R3 irq", 32'(irq_o), 0);
  endtask

  task automatic t_relax_resend_R9;
    do_cmd(3'd2, 32'hFF);
    check("R9 resend", 32'(resend_valid), 1);
    check("R9 no reject", 32'(rej_valid), 0);
    check("R9 irq", 32'(irq_o), 0);
  endtask

  task automatic t_offers_R4_R5;
    do_offer(24'h10, 8'h5);
    check("R5 taken no reject", 32'(rej_valid), 0);
    check("R5 irq", 32'(irq_o), 1);
    poll_expect("R5", 32'hFF000010, 8'hFF);
    do_offer(24'h11, 8'h5);
    check("R4 reject", 32'(rej_valid), 1);
    check("R4 reject src", 32'(rej_src), 32'h11);
    poll_expect("R4", 32'hFF000010, 8'hFF);
    do_offer(24'h12, 8'h3);
    check("R5 displaced", 32'(rej_valid), 1);
    check("R5 displaced src", 32'(rej_src), 32'h10);
    poll_expect("R5 new", 32'hFF000012, 8'hFF);
  endtask

  task automatic t_collision_R2;
    @(negedge clk);
    offer_valid = 1'b1; offer_src = 24'h30; offer_prio = 8'h1;
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = 32'h0;
    #1;
    check("R2 offer_ready low", 32'(offer_ready), 0);
    @(posedge clk); #1;
    offer_valid = 1'b0; cmd_valid = 1'b0;
    check("R2 cmd served", 32'(rsp_valid), 1);
    check("R2 offer not taken", 32'(rej_valid), 0);
    poll_expect("R2", 32'hFF000012, 8'hFF);
  endtask

  task automatic t_accept_R6;
    do_cmd(3'd0, 32'h0);
    check("R6 rsp valid", 32'(rsp_valid), 1);
    check("R6 rsp word", rsp_word, 32'hFF000012);
    check("R6 irq", 32'(irq_o), 0);
    poll_expect("R6", 32'h03000000, 8'hFF);
  endtask

  task automatic t_eoi_R7;
    do_cmd(3'd1, 32'hFF000012);
    check("R7 eoi", 32'(eoi_valid), 1);
    check("R7 eoi src", 32'(eoi_src), 32'h12);
    check("R7 resend", 32'(resend_valid), 1);
    poll_expect("R7", 32'hFF000000, 8'hFF);
  endtask

  task automatic t_ipi_R10;
    do_cmd(3'd3, 32'h4);
    check("R10 irq", 32'(irq_o), 1);
    poll_expect("R10 present", 32'hFF000002, 8'h04);
    do_offer(24'h20, 8'h2);
    check("R10 ipi displaced src", 32'(rej_src), 32'h2);
    do_cmd(3'd3, 32'h6);
    check("R10 no present", 32'(rej_valid), 0);
    poll_expect("R10 kept", 32'hFF000020, 8'h06);
    do_cmd(3'd3, 32'h1);
    check("R10 displace", 32'(rej_valid), 1);
    check("R10 displace src", 32'(rej_src), 32'h20);
    poll_expect("R10 win", 32'hFF000002, 8'h01);
  endtask

  task automatic t_tighten_R8;
    do_cmd(3'd2, 32'h1);
    check("R8 reject", 32'(rej_valid), 1);
    check("R8 reject src", 32'(rej_src), 32'h2);
    check("R8 irq", 32'(irq_o), 0);
    check("R8 no resend", 32'(resend_valid), 0);
    poll_expect("R8", 32'h01000000, 8'h01);
  endtask

  task automatic t_undef_R12;
    do_cmd(3'd7, 32'hFFFFFFFF);
    check("R12 quiet", 32'({rsp_valid, rej_valid, eoi_valid, resend_valid}), 0);
    poll_expect("R12", 32'h01000000, 8'h01);
  endtask

  task automatic t_resend_ipi_R9;
    do_cmd(3'd2, 32'h5);
    check("R9 resend", 32'(resend_valid), 1);
    check("R9 ipi irq", 32'(irq_o), 1);
    poll_expect("R9", 32'h05000002, 8'h01);
    do_cmd(3'd2, 32'h3);  // tighter, pending 1 stays
    check("R8 keep", 32'(rej_valid), 0);
    check("R8 keep irq", 32'(irq_o), 1);
    check("R8 keep no resend", 32'(resend_valid), 0);
    poll_expect("R8 keep", 32'h03000002, 8'h01);
  endtask

  task automatic t_poll_R11;
    poll_expect("R11 first", 32'h03000002, 8'h01);
    check("R11 irq", 32'(irq_o), 1);
    poll_expect("R11 second", 32'h03000002, 8'h01);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_R1();
    t_offer_blocked_R3();
    t_relax_resend_R9();
    t_offers_R4_R5();
    t_collision_R2();
    t_accept_R6();
    t_eoi_R7();
    t_ipi_R10();
    t_tighten_R8();
    t_undef_R12();
    t_resend_ipi_R9();
    t_poll_R11();
    finish_run();
  end
endmodule